// File: doc/BRIEF.md
# Mailbox Command Decoder with Microsecond Timer

This block sits behind a host-to-controller mailbox. When the host signals that a message is waiting, the block reads the packed header in mailbox word 0 and the interval in word 1 in that same cycle. The header holds a command code, a sequence number and a set of control flags. If the host asked for an acknowledge, the block sends a one-cycle "message read" request toward the host doorbell. If the command is timer control, the block starts, restarts or cancels a one-shot microsecond timer. It sends a one-cycle "timer expiry" request toward the doorbell when that timer runs out. Every other command is dropped without effect.

A divide-by-`CLKS_PER_US` prescaler turns the core clock into microsecond ticks, and a 64-bit down-counter holds the interval. Each message is decoded in a single cycle, so the host may present a new message on every clock and none is lost.

Top module: `mbox_cmd_timer`

## Requirements
- R1: Header word 0 is decoded as command code in bits [15:0], sequence number in bits [31:16] and control flags in bits [47:32]. The sequence number and bits [63:48] have no effect on either output.
- R2: When a message is accepted with flag bit 9 set (word 0 bit 41, value 0x0200), `ack_evt` is high for exactly the one cycle after the accepting edge. Otherwise `ack_evt` is low in that cycle.
- R3: A message with command code 0xD401, flag bit 0 set (start) and flag bit 1 clear arms the timer with interval N taken from word 1. `expiry_evt` then rises in the cycle after clock edge max(N,1)·CLKS_PER_US, counting the accepting edge as edge 0. An interval of 0 therefore expires on the first tick.
- R4: A message with command code 0xD401 and flag bit 1 set (stop) cancels the timer, so no expiry follows. This holds even when the start flag is set in the same message.
- R5: A start while the timer is running reloads the interval and restarts the prescaler. Expiry is then timed from the new message only.
- R6: An expiry is a single-cycle pulse, after which the timer is idle and raises no further expiry until it is started again.
- R7: A message with any command code other than 0xD401 leaves the timer untouched, whatever its flags, including one that arrives while a timer is running. Only its acknowledge is handled.
- R8: Messages presented on consecutive cycles are each decoded, and each produces its own acknowledge decision one cycle later.
- R9: After reset both event outputs are low and the timer is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_pending | input | 1 | High for one cycle per message waiting in the mailbox |
| mbox_w0 | input | 64 | Mailbox word 0: packed command header |
| mbox_w1 | input | 64 | Mailbox word 1: timer interval in microseconds |
| ack_evt | output | 1 | One-cycle request to set the "message read" doorbell bit |
| expiry_evt | output | 1 | One-cycle request to set the "timer expiry" doorbell bit |

## Verification
The bound checker checks on every cycle that the acknowledge output follows the acknowledge flag of the message accepted one cycle earlier. It also checks that a stop command leaves the timer idle, that a plain start leaves it running, that a non-timer command never wakes an idle timer, and that each expiry lasts one cycle and leaves the timer idle. Exact expiry timing depends on the interval and the prescaler, so only the bench scenarios show it. The same holds for the reload on restart, for a non-timer message arriving mid-count, and for the zero-interval case. Those scenarios measure the delay from the accepting edge to the expiry pulse against a value the bench computes.

// File: rtl/mbox_cmd_timer.sv
module mbox_cmd_timer #(
  parameter int          CLKS_PER_US = 100,
  parameter logic [15:0] TIMER_CMD   = 16'hD401
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        msg_pending,
  input  logic [63:0] mbox_w0,
  input  logic [63:0] mbox_w1,
  output logic        ack_evt,
  output logic        expiry_evt
);
  localparam int PW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CLKS_PER_US - 1);

  logic          running;
  logic [PW-1:0] presc;
  logic [63:0]   remain;

  wire [15:0] cmd_code  = mbox_w0[15:0];
  wire [15:0] hdr_flags = mbox_w0[47:32];
  wire        unused_hdr = ^{mbox_w0[63:48], mbox_w0[31:16], hdr_flags[15:10], hdr_flags[8:2]};

  wire is_timer = msg_pending && (cmd_code == TIMER_CMD);
  wire do_stop  = is_timer && hdr_flags[1];
  wire do_start = is_timer && hdr_flags[0] && !hdr_flags[1];
  wire tick     = (presc == PRE_LAST);
  wire last_us  = (remain <= 64'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_evt    <= 1'b0;
      expiry_evt <= 1'b0;
      running    <= 1'b0;
      presc      <= '0;
      remain     <= '0;
    end else begin
      ack_evt    <= msg_pending && hdr_flags[9];
      expiry_evt <= 1'b0;
      if (do_stop) begin
        running <= 1'b0;
        presc   <= '0;
      end else if (do_start) begin
        running <= 1'b1;
        presc   <= '0;
        remain  <= mbox_w1;
      end else if (running) begin
        if (tick) begin
          presc <= '0;
          if (last_us) begin
            running    <= 1'b0;
            expiry_evt <= 1'b1;
          end else begin
            remain <= remain - 64'd1;
          end
        end else begin
          presc <= presc + PW'(1);
        end
      end
    end
  end
endmodule

module mbox_cmd_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        msg_pending,
  input logic [15:0] cmd,
  input logic        f_start,
  input logic        f_stop,
  input logic        f_ack,
  input logic        ack_evt,
  input logic        expiry_evt,
  input logic        running
);
  assert_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_pending && f_ack) |=> ack_evt);
  assert_noack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(msg_pending && f_ack) |=> !ack_evt);
  assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_pending && cmd == 16'hD401 && f_start && !f_stop) |=> running);
  assert_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_pending && cmd == 16'hD401 && f_stop) |=> (!running && !expiry_evt));
  assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expiry_evt |=> !expiry_evt);
  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expiry_evt |-> !running);
  assert_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_pending && cmd != 16'hD401 && !running) |=> (!running && !expiry_evt));
endmodule

bind mbox_cmd_timer mbox_cmd_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .msg_pending(msg_pending),
  .cmd(mbox_w0[15:0]), .f_start(mbox_w0[32]), .f_stop(mbox_w0[33]),
  .f_ack(mbox_w0[41]), .ack_evt(ack_evt), .expiry_evt(expiry_evt),
  .running(running)
);

// File: tb/mbox_cmd_timer_bench.sv
module mbox_cmd_timer_bench;
  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_pending = 1'b0;
  logic [63:0] mbox_w0 = '0;
  logic [63:0] mbox_w1 = '0;
  logic        ack_evt, expiry_evt;

  int checks = 0;
  int fails  = 0;

  mbox_cmd_timer #(.CLKS_PER_US(P)) u_mbox_cmd_timer (
    .clk(clk), .rst_n(rst_n), .msg_pending(msg_pending),
    .mbox_w0(mbox_w0), .mbox_w1(mbox_w1),
    .ack_evt(ack_evt), .expiry_evt(expiry_evt)
  );

  always #5 clk = ~clk;

  function automatic int exp_cycles(input longint n);
    return (n == 0) ? P : int'(n) * P;
  endfunction

  function automatic logic [63:0] hdr(input logic [15:0] cmd, input logic [15:0] flags,
                                      input logic [15:0] seq, input logic [15:0] top);
    return {top, flags, seq, cmd};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] w0, input logic [63:0] w1, output bit ack);
    @(negedge clk);
    msg_pending = 1'b1; mbox_w0 = w0; mbox_w1 = w1;
    @(negedge clk);
    ack = ack_evt;
    msg_pending = 1'b0;
  endtask

  task automatic wait_exp(input int limit, output int first, output int pulses);
    first = 0; pulses = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (expiry_evt) begin
        pulses++;
        if (first == 0) first = i;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit a, a1, a2, a3;
    int first, pulses;
    void'($urandom(32'h5EED));

    repeat (3) @(negedge clk);
    chk(!ack_evt && !expiry_evt, "R9 reset outputs", {ack_evt, expiry_evt}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ack_evt && !expiry_evt, "R9 after release", {ack_evt, expiry_evt}, 0);

    // R3 zero and one microsecond
    send(hdr(16'hD401, 16'h0001, 16'h1234, 16'hFFFF), 64'd0, a);
    wait_exp(6 * P, first, pulses);
    chk(first == exp_cycles(0), "R3 zero interval", first, exp_cycles(0));
    chk(pulses == 1, "R6 single pulse zero", pulses, 1);
    send(hdr(16'hD401, 16'h0201, 16'h0000, 16'h0000), 64'd1, a);
    chk(a == 1'b1, "R2 ack with start", a, 1);
    wait_exp(6 * P, first, pulses);
    chk(first == exp_cycles(1), "R3 one interval", first, exp_cycles(1));

    // R5 restart reloads
    send(hdr(16'hD401, 16'h0001, 16'h0, 16'h0), 64'd10, a);
    repeat (8) @(negedge clk);
    chk(!expiry_evt, "R5 no early expiry", expiry_evt, 0);
    send(hdr(16'hD401, 16'h0001, 16'h0, 16'h0), 64'd3, a);
    wait_exp(14 * P, first, pulses);
    chk(first == exp_cycles(3), "R5 restart timing", first, exp_cycles(3));
    chk(pulses == 1, "R5 one pulse after restart", pulses, 1);

    // R7 other command while running
    send(hdr(16'hD401, 16'h0001, 16'h0, 16'h0), 64'd6, a);
    repeat (5) @(negedge clk);
    send(hdr(16'hD501, 16'h0203, 16'h0, 16'h0), 64'd1, a);
    chk(a == 1'b1, "R7 ack on other command", a, 1);
    wait_exp(10 * P, first, pulses);
    chk(first == exp_cycles(6) - 7, "R7 timer untouched", first, exp_cycles(6) - 7);

    // R4 stop cancels; both flags stop
    send(hdr(16'hD401, 16'h0001, 16'h0, 16'h0), 64'd5, a);
    repeat (3) @(negedge clk);
    send(hdr(16'hD401, 16'h0002, 16'h0, 16'h0), 64'd5, a);
    wait_exp(10 * P, first, pulses);
    chk(pulses == 0, "R4 stop cancels", pulses, 0);
    send(hdr(16'hD401, 16'h0003, 16'h0, 16'h0), 64'd2, a);
    wait_exp(6 * P, first, pulses);
    chk(pulses == 0, "R4 start and stop together", pulses, 0);

    // R8 back to back messages
    @(negedge clk);
    msg_pending = 1'b1; mbox_w0 = hdr(16'hD701, 16'h0200, 16'h1, 16'h0);
    @(negedge clk);
    a1 = ack_evt; mbox_w0 = hdr(16'hD702, 16'h0000, 16'h2, 16'h0);
    @(negedge clk);
    a2 = ack_evt; mbox_w0 = hdr(16'hD703, 16'h0200, 16'h3, 16'h0);
    @(negedge clk);
    a3 = ack_evt; msg_pending = 1'b0;
    chk({a1, a2, a3} == 3'b101, "R8 back to back acks", {a1, a2, a3}, 3'b101);
    @(negedge clk);
    chk(!ack_evt, "R2 ack one cycle", ack_evt, 0);

    // R1 R2 R3 R7 random mix
    for (int it = 0; it < 24; it++) begin
      logic [15:0] cmd;
      bit st, sp, ak, expire;
      int n, sel;
      sel = $urandom % 4;
      st = $urandom % 2; sp = ($urandom % 4) == 0; ak = $urandom % 2;
      n = $urandom % 21;
      case (sel)
        0, 1:    cmd = 16'hD401;
        2:       cmd = 16'hD400 | 16'($urandom % 8);
        default: cmd = 16'($urandom);
      endcase
      expire = (cmd == 16'hD401) && st && !sp;
      send(hdr(cmd, {6'b0, ak, 7'b0, sp, st}, 16'($urandom), 16'($urandom)), 64'(n), a);
      chk(a == ak, "R1 R2 random ack", a, ak);
      wait_exp(22 * P, first, pulses);
      if (expire) begin
        chk(first == exp_cycles(n), "R3 random expiry time", first, exp_cycles(n));
        chk(pulses == 1, "R6 random single pulse", pulses, 1);
      end else begin
        chk(pulses == 0, "R7 random no expiry", pulses, 0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule